// File: doc/BRIEF.md
# Three-Path Switchable Router Input Channel

This block is the receive side of one mesh router port. Each incoming flit leaves by one of three paths. The packet path writes flits into a small FIFO and releases them under the downstream handshake. The unbuffered circuit path is a plain wire from input to output. The buffered circuit path passes each flit through one pipeline register. Two multiplexer stages choose the path. The first stage picks between the circuit result and the FIFO head. The second stage, inside the circuit side, picks between the register and the bypass wire.

The two path-select inputs come from a mode controller outside this block. The channel samples them only when it accepts the first flit of a packet, and keeps that path until the next packet begins. It does not start a packet on a different path while the FIFO or the pipeline register still holds older flits. This keeps packets in order across a change of mode. Both sides use a valid/ack handshake: a flit moves in any cycle where valid and ack are both high.

Top module: `swmode_input_channel`

## Requirements
- R1: After a synchronous reset the output valid is low, the selected path is the packet path, and with the FIFO empty the input ack is high.
- R2: On the packet path (circuit select = 0), the channel accepts up to 4 flits while the output is stalled. It drops input ack while the FIFO is full. Flits leave in arrival order, starting the cycle after the first write.
- R3: On the unbuffered circuit path (circuit select = 1, buffered select = 0), output valid equals input valid, output flit equals input flit, and input ack equals output ack, all in the same cycle.
- R4: On the buffered circuit path (circuit select = 1, buffered select = 1), an accepted flit appears at the output on the next cycle. It is held stable while output ack is low, and input ack is low while the register is full and output ack is low.
- R5: On the buffered circuit path, the register reloads in the same cycle its contents are taken, so with output ack held high it moves one flit per cycle.
- R6: The path is sampled when a head flit is accepted. Changing the select inputs in the middle of a packet does not affect the flits that follow.
- R7: A head flit that asks for a path other than the current one gets input ack low while the FIFO or the register holds flits. It is accepted once they have drained.
- R8: Flit bit 15 marks a head flit and bit 14 marks a tail flit. A flit with both bits set is a complete one-flit packet and closes the packet at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_circuit_i | input | 1 | Path request: 1 = circuit, 0 = packet FIFO |
| mode_buffered_i | input | 1 | Circuit variant: 1 = through register, 0 = bypass wire |
| in_valid_i | input | 1 | Upstream flit valid |
| in_flit_i | input | 16 | Upstream flit (bit 15 head, bit 14 tail) |
| in_ack_o | output | 1 | Flit taken this cycle when valid is also high |
| out_valid_o | output | 1 | Flit valid toward the crossbar |
| out_flit_o | output | 16 | Flit toward the crossbar |
| out_ack_i | input | 1 | Crossbar takes the flit this cycle |

## Verification
Each path gets one packet with output ack held low. This separates them by the cycle the flit first shows at the output: the same cycle for the bypass, one cycle later for the register, and after the FIFO write for the packet path. It also shows how many flits each path absorbs before it pushes back. The buffered path is then driven with ack held high, to tell a register that reloads while draining from one that loses every second cycle. A packet whose select inputs flip halfway through checks that the mode is latched. A head flit asking for a new path while older flits sit in the FIFO or the register checks that it waits, and that it goes through once they drain. A one-flit packet confirms that head and tail on the same flit close the packet.

// File: rtl/swmode_pkg.sv
package swmode_pkg;

    localparam int FLIT_W     = 16;
    localparam int FIFO_DEPTH = 4;

    typedef enum logic [1:0] {
        PATH_PKT = 2'd0,
        PATH_UCS = 2'd1,
        PATH_BCS = 2'd2
    } path_e;

    typedef struct packed {
        logic circuit;
        logic buffered;
    } mode_sel_t;

    function automatic path_e decode_path(mode_sel_t m);
        if (!m.circuit)
            return PATH_PKT;
        return m.buffered ? PATH_BCS : PATH_UCS;
    endfunction

endpackage

// File: rtl/swmode_fifo.sv
module swmode_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            if (push && !pop)
                count <= count + 1'b1;
            else if (pop && !push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/swmode_stage_reg.sv
module swmode_stage_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         drain,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else begin
            if (load)
                dout <= din;
            if (load)
                full <= 1'b1;
            else if (drain)
                full <= 1'b0;
        end
    end
endmodule

// File: rtl/swmode_path_ctrl.sv
module swmode_path_ctrl
    import swmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_head,
    input  logic  in_tail,
    input  logic  in_ack,
    input  path_e req_path,
    input  logic  store_empty,
    output path_e eff_path,
    output path_e cur_path,
    output logic  hold_wait,
    output logic  pkt_open
);
    logic head_now;
    logic taken;

    assign head_now  = in_valid && !pkt_open && in_head;
    assign hold_wait = head_now && (req_path != cur_path) && !store_empty;
    assign taken     = in_valid && in_ack;

    always_comb begin
        if (head_now && !hold_wait)
            eff_path = req_path;
        else
            eff_path = cur_path;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_path <= PATH_PKT;
            pkt_open <= 1'b0;
        end else if (taken) begin
            if (head_now) begin
                cur_path <= req_path;
                pkt_open <= !in_tail;
            end else if (pkt_open && in_tail) begin
                pkt_open <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/swmode_input_channel.sv
module swmode_input_channel
    import swmode_pkg::*;
#(
    parameter int FW    = swmode_pkg::FLIT_W,
    parameter int DEPTH = swmode_pkg::FIFO_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_circuit_i,
    input  logic          mode_buffered_i,
    input  logic          in_valid_i,
    input  logic [FW-1:0] in_flit_i,
    output logic          in_ack_o,
    output logic          out_valid_o,
    output logic [FW-1:0] out_flit_o,
    input  logic          out_ack_i
);
    localparam int HEAD_BIT = FW - 1;
    localparam int TAIL_BIT = FW - 2;

    mode_sel_t     req_sel;
    path_e         req_path, eff_path, cur_path;
    logic          hold_wait, pkt_open, store_empty;
    logic          fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [FW-1:0] fifo_head;
    logic          reg_load, reg_drain, reg_full;
    logic [FW-1:0] reg_q;
    logic          take, sel_circuit, sel_buffered, path_ack;
    logic          circ_valid;
    logic [FW-1:0] circ_flit;

    assign req_sel     = '{circuit: mode_circuit_i, buffered: mode_buffered_i};
    assign req_path    = decode_path(req_sel);
    assign store_empty = fifo_empty && !reg_full;

    swmode_path_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid_i),
        .in_head    (in_flit_i[HEAD_BIT]),
        .in_tail    (in_flit_i[TAIL_BIT]),
        .in_ack     (in_ack_o),
        .req_path   (req_path),
        .store_empty(store_empty),
        .eff_path   (eff_path),
        .cur_path   (cur_path),
        .hold_wait  (hold_wait),
        .pkt_open   (pkt_open)
    );

    assign sel_circuit  = (eff_path != PATH_PKT);
    assign sel_buffered = (eff_path == PATH_BCS);

    always_comb begin
        unique case (eff_path)
            PATH_UCS: path_ack = out_ack_i;
            PATH_BCS: path_ack = !reg_full || out_ack_i;
            default:  path_ack = !fifo_full;
        endcase
    end

    assign in_ack_o  = path_ack && !hold_wait;
    assign take      = in_valid_i && in_ack_o;
    assign fifo_push = take && !sel_circuit;
    assign reg_load  = take && sel_buffered;

    swmode_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (fifo_push),
        .din  (in_flit_i),
        .pop  (fifo_pop),
        .dout (fifo_head),
        .empty(fifo_empty),
        .full (fifo_full)
    );

    swmode_stage_reg #(.W(FW)) u_stage (
        .clk  (clk),
        .rst  (rst),
        .load (reg_load),
        .drain(reg_drain),
        .din  (in_flit_i),
        .dout (reg_q),
        .full (reg_full)
    );

    // second stage: buffered or unbuffered circuit
    assign circ_valid = sel_buffered ? reg_full : (in_valid_i && !hold_wait);
    assign circ_flit  = sel_buffered ? reg_q    : in_flit_i;

    // first stage: circuit or packet
    assign out_valid_o = sel_circuit ? circ_valid : !fifo_empty;
    assign out_flit_o  = sel_circuit ? circ_flit  : fifo_head;

    assign fifo_pop  = out_valid_o && out_ack_i && !sel_circuit;
    assign reg_drain = out_valid_o && out_ack_i && sel_buffered;
endmodule

// File: rtl/swmode_input_channel_chk.sv
module swmode_input_channel_chk
    import swmode_pkg::*;
#(
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ack,
    input logic [FW-1:0] in_flit,
    input logic          out_valid,
    input logic          out_ack,
    input logic [FW-1:0] out_flit,
    input path_e         eff_path,
    input path_e         cur_path,
    input logic          pkt_open,
    input logic          store_empty,
    input logic          fifo_full,
    input logic          fifo_push
);
    a_r3_ucs_wire: assert property (@(posedge clk) disable iff (rst)
        (eff_path == PATH_UCS) |->
            (out_valid == in_valid && in_ack == out_ack && out_flit == in_flit));

    a_r4_bcs_hold: assert property (@(posedge clk) disable iff (rst)
        (eff_path == PATH_BCS && out_valid && !out_ack) |=>
            (out_valid && $stable(out_flit)));

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !fifo_push);

    a_r7_switch_drained: assert property (@(posedge clk) disable iff (rst)
        (cur_path != $past(cur_path)) |-> $past(store_empty));

    a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
        $past(pkt_open) |-> $stable(cur_path));
endmodule

bind swmode_input_channel swmode_input_channel_chk #(.FW(FW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid_i),
    .in_ack     (in_ack_o),
    .in_flit    (in_flit_i),
    .out_valid  (out_valid_o),
    .out_ack    (out_ack_i),
    .out_flit   (out_flit_o),
    .eff_path   (eff_path),
    .cur_path   (cur_path),
    .pkt_open   (pkt_open),
    .store_empty(store_empty),
    .fifo_full  (fifo_full),
    .fifo_push  (fifo_push)
);

// File: tb/swmode_input_channel_tb.sv
module swmode_input_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_circuit = 1'b0, mode_buffered = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_flit = '0;
    logic        in_ack, out_valid, out_ack = 1'b0;
    logic [15:0] out_flit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    swmode_input_channel u_dut (
        .clk            (clk),
        .rst            (rst),
        .mode_circuit_i (mode_circuit),
        .mode_buffered_i(mode_buffered),
        .in_valid_i     (in_valid),
        .in_flit_i      (in_flit),
        .in_ack_o       (in_ack),
        .out_valid_o    (out_valid),
        .out_flit_o     (out_flit),
        .out_ack_i      (out_ack)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        rst = 1'b0;
        settle();
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 in_ack after reset", in_ack, 1);
    endtask

    task automatic t_packet_fifo();
        logic [15:0] f [4];
        f[0] = 16'h8001; f[1] = 16'h0002; f[2] = 16'h0003; f[3] = 16'h4004;
        mode_circuit = 0; out_ack = 0;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1; in_flit = f[i];
            settle();
            chk("R2 accept while not full", in_ack, 1);
            if (i == 0) chk("R2 fifo not visible same cycle", out_valid, 0);
            tick();
        end
        in_flit = 16'hC055;
        settle();
        chk("R2 ack low when full", in_ack, 0);
        chk("R2 head at output", out_flit, f[0]);
        in_valid = 0; out_ack = 1;
        for (int i = 0; i < 4; i++) begin
            settle();
            chk("R2 out_valid draining", out_valid, 1);
            chk("R2 order", out_flit, f[i]);
            tick();
        end
        settle();
        chk("R2 empty after drain", out_valid, 0);
    endtask

    task automatic t_mode_latch_and_wait();
        mode_circuit = 0; mode_buffered = 0; out_ack = 0;
        in_valid = 1; in_flit = 16'h8111;
        tick();
        mode_circuit = 1;
        in_flit = 16'h0222;
        settle();
        chk("R6 body still on packet path (ack)", in_ack, 1);
        chk("R6 output shows fifo head", out_flit, 16'h8111);
        tick();
        in_flit = 16'h4333;
        settle();
        chk("R6 tail still on packet path", in_ack, 1);
        tick();
        in_flit = 16'h8444;
        settle();
        chk("R7 new-path head waits", in_ack, 0);
        chk("R7 fifo head still out", out_flit, 16'h8111);
        tick();
        out_ack = 1;
        settle();
        chk("R7 drain 1", out_flit, 16'h8111);
        chk("R7 still waiting 1", in_ack, 0);
        tick();
        chk("R7 drain 2", out_flit, 16'h0222);
        chk("R7 still waiting 2", in_ack, 0);
        tick();
        chk("R7 drain 3", out_flit, 16'h4333);
        chk("R7 still waiting 3", in_ack, 0);
        tick();
        chk("R7 head accepted after drain", in_ack, 1);
        chk("R7 head bypasses", out_flit, 16'h8444);
        tick();
        in_flit = 16'h4555;
        tick();
        in_valid = 0;
    endtask

    task automatic t_unbuffered();
        mode_circuit = 1; mode_buffered = 0; out_ack = 0;
        in_valid = 1; in_flit = 16'h8ABC;
        settle();
        chk("R3 valid passes through", out_valid, 1);
        chk("R3 flit passes through", out_flit, 16'h8ABC);
        chk("R3 ack follows out_ack low", in_ack, 0);
        out_ack = 1;
        settle();
        chk("R3 ack follows out_ack high", in_ack, 1);
        tick();
        in_flit = 16'h4DEF;
        settle();
        chk("R3 tail passes through", out_flit, 16'h4DEF);
        tick();
        in_valid = 0;
        settle();
        chk("R3 valid drops with input", out_valid, 0);
    endtask

    task automatic t_buffered();
        mode_circuit = 1; mode_buffered = 1; out_ack = 0;
        in_valid = 1; in_flit = 16'h8010;
        settle();
        chk("R4 accepted into empty register", in_ack, 1);
        chk("R4 not visible same cycle", out_valid, 0);
        tick();
        in_flit = 16'h0020;
        settle();
        chk("R4 visible next cycle", out_flit, 16'h8010);
        chk("R4 valid next cycle", out_valid, 1);
        chk("R4 ack low while full and stalled", in_ack, 0);
        tick();
        chk("R4 held while stalled", out_flit, 16'h8010);
        out_ack = 1;
        settle();
        chk("R5 reload while draining", in_ack, 1);
        tick();
        in_flit = 16'h0030;
        settle();
        chk("R5 stream 1", out_flit, 16'h0020);
        chk("R5 ack stays high", in_ack, 1);
        tick();
        in_flit = 16'h4040;
        settle();
        chk("R5 stream 2", out_flit, 16'h0030);
        tick();
        in_valid = 0;
        settle();
        chk("R5 stream 3", out_flit, 16'h4040);
        chk("R5 stream 3 valid", out_valid, 1);
        tick();
        chk("R5 empty after stream", out_valid, 0);
    endtask

    task automatic t_single_flit();
        mode_circuit = 1; mode_buffered = 1; out_ack = 0;
        in_valid = 1; in_flit = 16'hC0AA;
        tick();
        mode_circuit = 0; in_flit = 16'h8BB0;
        settle();
        chk("R8 new head waits on full register", in_ack, 0);
        out_ack = 1;
        settle();
        chk("R8 one-flit packet closed, head still waits", in_ack, 0);
        chk("R8 one-flit packet out", out_flit, 16'hC0AA);
        tick();
        chk("R8 head accepted after drain", in_ack, 1);
        chk("R8 packet path latency", out_valid, 0);
        tick();
        in_valid = 0;
        settle();
        chk("R8 head out of fifo", out_flit, 16'h8BB0);
        chk("R8 fifo valid", out_valid, 1);
        tick();
        in_valid = 1; in_flit = 16'h4BB1;
        tick();
        in_valid = 0;
        tick();
        tick();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1;
        t_reset();
        t_packet_fifo();
        t_mode_latch_and_wait();
        t_unbuffered();
        t_buffered();
        t_single_flit();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule